// File: doc/BRIEF.md
# Indexed-Read 64-bit Event Counter Monitor

This block watches a wide vector of single-bit event lines and keeps eight 64-bit counters. Each counter has its own configuration word. The word picks one event line by number, sets the line's active polarity, and chooses between counting the cycles the line spends active and counting each transition into the active level. A global control word gates all counters together. It also offers a one-shot clear that zeroes every counter at once.

The counters are not mapped into the register space directly. Software first writes a selector code, which is 8 plus the counter number. It then reads the chosen counter through two 32-bit windows. A read of the upper window captures the lower half at the same instant, so a 64-bit value read as upper then lower stays coherent while counting goes on. Read data appears on the cycle after the read strobe.

Top module: `evt_cnt_mon`

## Requirements
- R1: After reset all counters are zero, and every register (control, selector, configuration words, both windows) reads 0.
- R2: Counter n has a configuration word at byte address 0x10C + 4*n. Bits [11:0] are writable and read back, and bits [31:12] read 0.
- R3: The control word at 0x108 holds enable in bit 0 and start in bit 1, and both read back. A counter can increment only while both are 1. Writing 0 freezes every counter.
- R4: Bit 4 of a control write clears all eight counters at the clock edge of that write. The clear wins over an increment at the same edge. The bit is not stored and reads 0.
- R5: With configuration bit 11 = 0 (level mode), a running counter increments on every cycle its line is active. Bit 10 = 1 means active high, and bit 10 = 0 means active low.
- R6: With configuration bit 11 = 1 (edge mode), a running counter increments once per transition into the active level: a rising edge when bit 10 = 1, a falling edge when bit 10 = 0.
- R7: Configuration bits [9:0] are the event line number. A value of 0x200 or above (bit 9 set) names no line, and that counter never increments.
- R8: The selector at 0x12C keeps bits [3:0] and reads them back. Code 8 + n chooses counter n. Codes 0 to 7 choose nothing, and both windows then read 0.
- R9: A read at 0x134 returns bits [63:32] of the selected counter and captures bits [31:0] at the same edge. The next read at 0x130 returns that captured value. A read at 0x130 with no pending capture returns the live low half.
- R10: Read data is registered and valid the cycle after the read strobe. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| events_i | input | 512 | Event lines, indexed by configuration bits [8:0] |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |

## Verification
The bench first aims at the window pair. It reads the upper half, lets the counter run, and then reads the lower half. A design that did not capture at the upper read would return a low half that has moved on. It also reads the lower window twice, and a design that kept the capture pending would return a stale value on the second read. A clear written while a counter is incrementing must leave it at zero, not one. Selector codes below 8 must read zero rather than alias onto a counter. In edge mode the two polarities are driven against a toggling line to catch a swapped or missing previous-value register. Event numbers with bit 9 set must never count, which catches a decoder that drops that bit and folds the number onto a low line.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int ID_W = 10;

  typedef struct packed {
    logic            edge_mode;
    logic            act_high;
    logic [ID_W-1:0] evt_id;
  } evt_cfg_t;

  localparam int CFG_W = ID_W + 2;

  localparam logic [11:0] ADR_CTRL = 12'h108;
  localparam logic [11:0] ADR_CFG0 = 12'h10C;
  localparam logic [11:0] ADR_SEL  = 12'h12C;
  localparam logic [11:0] ADR_LO   = 12'h130;
  localparam logic [11:0] ADR_HI   = 12'h134;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_GO  = 1;
  localparam int CTRL_CLR = 4;

  localparam logic [3:0] SEL_OFS = 4'd8;
endpackage

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int NUM_EVT = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               clr_i,
  input  evt_cfg_t           cfg_i,
  input  logic [NUM_EVT-1:0] events_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int EVT_IDX_W = $clog2(NUM_EVT);

  logic id_ok, line, lvl, prev_lvl, hit, prev_q;
  logic [CNT_W-1:0] cnt_q;

  assign id_ok    = {{(32-ID_W){1'b0}}, cfg_i.evt_id} < 32'(NUM_EVT);
  assign line     = id_ok ? events_i[cfg_i.evt_id[EVT_IDX_W-1:0]] : 1'b0;
  assign lvl      = cfg_i.act_high ? line : ~line;
  assign prev_lvl = cfg_i.act_high ? prev_q : ~prev_q;
  assign hit      = id_ok && (cfg_i.edge_mode ? (lvl && !prev_lvl) : lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= line;
      if (clr_i)             cnt_q <= '0;
      else if (run_i && hit) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  a_r4_clr_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
  a_r5_step_of_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r7_bad_id_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cfg_i.evt_id[ID_W-1]) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_cnt_rdwin.sv
module evt_cnt_rdwin #(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_hi_i,
  input  logic                rd_lo_i,
  input  logic                sel_ok_i,
  input  logic [2*DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o
);
  logic [DATA_W-1:0] shadow_q, live_lo;
  logic              shv_q;

  assign live_lo = sel_ok_i ? cnt_i[DATA_W-1:0] : '0;
  assign hi_o    = sel_ok_i ? cnt_i[2*DATA_W-1:DATA_W] : '0;
  assign lo_o    = shv_q ? shadow_q : live_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      shv_q    <= 1'b0;
    end else if (rd_hi_i) begin
      shadow_q <= live_lo;
      shv_q    <= 1'b1;
    end else if (rd_lo_i) begin
      shv_q    <= 1'b0;
    end
  end

  a_r9_lo_consumes_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i) |=> !shv_q);
endmodule

// File: rtl/evt_cnt_mon.sv
module evt_cnt_mon
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int NUM_EVT = 512,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] events_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int SEL_W = $clog2(NUM_CNT);

  evt_cfg_t          cfg_q [NUM_CNT];
  logic [CNT_W-1:0]  cnt_w [NUM_CNT];
  logic              en_q, go_q, run, clr, wr_ctrl, sel_ok;
  logic [3:0]        sel_q, sel_n;
  logic [SEL_W-1:0]  sel_idx;
  logic [DATA_W-1:0] hi_w, lo_w, rd_mux;

  assign wr_ctrl = wr_en_i && addr_i == ADDR_W'(ADR_CTRL);
  assign clr     = wr_ctrl && wdata_i[CTRL_CLR];
  assign run     = en_q && go_q;
  assign sel_n   = sel_q - SEL_OFS;
  assign sel_ok  = (sel_q >= SEL_OFS) && (32'(sel_n) < 32'(NUM_CNT));
  assign sel_idx = sel_n[SEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      go_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= wdata_i[CTRL_EN];
        go_q <= wdata_i[CTRL_GO];
      end
      if (wr_en_i && addr_i == ADDR_W'(ADR_SEL)) sel_q <= wdata_i[3:0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] CFG_ADR = ADDR_W'(ADR_CFG0) + ADDR_W'(4*i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cfg_q[i] <= '0;
      else if (wr_en_i && addr_i == CFG_ADR)  cfg_q[i] <= evt_cfg_t'(wdata_i[CFG_W-1:0]);
    end

    evt_cnt_slice #(
      .CNT_W  (CNT_W),
      .NUM_EVT(NUM_EVT)
    ) i_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .clr_i   (clr),
      .cfg_i   (cfg_q[i]),
      .events_i(events_i),
      .cnt_o   (cnt_w[i])
    );
  end

  evt_cnt_rdwin #(.DATA_W(DATA_W)) i_rdwin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_hi_i (rd_en_i && addr_i == ADDR_W'(ADR_HI)),
    .rd_lo_i (rd_en_i && addr_i == ADDR_W'(ADR_LO)),
    .sel_ok_i(sel_ok),
    .cnt_i   (cnt_w[sel_idx]),
    .hi_o    (hi_w),
    .lo_o    (lo_w)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(ADR_CTRL)) begin
      rd_mux[CTRL_EN] = en_q;
      rd_mux[CTRL_GO] = go_q;
    end
    if (addr_i == ADDR_W'(ADR_SEL)) rd_mux[3:0] = sel_q;
    if (addr_i == ADDR_W'(ADR_HI))  rd_mux = hi_w;
    if (addr_i == ADDR_W'(ADR_LO))  rd_mux = lo_w;
    for (int i = 0; i < NUM_CNT; i++)
      if (addr_i == ADDR_W'(ADR_CFG0) + ADDR_W'(4*i)) rd_mux[CFG_W-1:0] = cfg_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  a_r4_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(ADR_CTRL)) |=> rdata_o[CTRL_CLR] == 1'b0);
  a_r8_no_sel_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(ADR_HI) && sel_q < SEL_OFS) |=> rdata_o == '0);
  a_r10_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/test_evt_cnt_mon.sv
module test_evt_cnt_mon;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0]  addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [511:0] events_i = '0, ev_dir = '0;
  logic         ev_rand = 1'b0;
  logic [31:0]  rdata_o;
  int checks = 0, errors = 0;
  bit done = 0;

  evt_cnt_mon i_evt_cnt_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .events_i(events_i), .rdata_o(rdata_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (ev_rand) for (int w = 0; w < 16; w++) events_i[w*32 +: 32] <= $urandom;
    else events_i <= ev_dir;
  end

  // reference model
  logic [63:0] m_cnt [8];
  logic [11:0] m_cfg [8];
  logic        m_prev [8];
  logic        m_en, m_go, m_shv;
  logic [3:0]  m_sel;
  logic [31:0] m_shadow, m_rdata;

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic ok;
    ok = m_sel >= 4'd8;
    if (a == 12'h108) return {30'b0, m_go, m_en};
    if (a == 12'h12C) return {28'b0, m_sel};
    if (a == 12'h134) return ok ? m_cnt[m_sel[2:0]][63:32] : 32'h0;
    if (a == 12'h130) return m_shv ? m_shadow : (ok ? m_cnt[m_sel[2:0]][31:0] : 32'h0);
    if (a >= 12'h10C && a < 12'h12C && a[1:0] == 2'b00) return {20'b0, m_cfg[(a - 12'h10C) >> 2]};
    return 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) begin m_cnt[i] <= '0; m_cfg[i] <= '0; m_prev[i] <= 1'b0; end
      m_en <= 0; m_go <= 0; m_shv <= 0; m_sel <= '0; m_shadow <= '0; m_rdata <= '0;
    end else begin
      if (rd_en_i) begin
        m_rdata <= m_read(addr_i);
        if (addr_i == 12'h134) begin
          m_shadow <= (m_sel >= 4'd8) ? m_cnt[m_sel[2:0]][31:0] : 32'h0;
          m_shv <= 1'b1;
        end else if (addr_i == 12'h130) m_shv <= 1'b0;
      end
      if (wr_en_i) begin
        if (addr_i == 12'h108) begin m_en <= wdata_i[0]; m_go <= wdata_i[1]; end
        if (addr_i == 12'h12C) m_sel <= wdata_i[3:0];
        for (int i = 0; i < 8; i++)
          if (addr_i == 12'h10C + 12'(4*i)) m_cfg[i] <= wdata_i[11:0];
      end
      for (int i = 0; i < 8; i++) begin
        automatic logic ok = !m_cfg[i][9];
        automatic logic ln = ok ? events_i[m_cfg[i][8:0]] : 1'b0;
        automatic logic lv = m_cfg[i][10] ? ln : !ln;
        automatic logic pv = m_cfg[i][10] ? m_prev[i] : !m_prev[i];
        automatic logic h  = ok && (m_cfg[i][11] ? (lv && !pv) : lv);
        m_prev[i] <= ln;
        if (wr_en_i && addr_i == 12'h108 && wdata_i[4]) m_cnt[i] <= '0;
        else if (m_en && m_go && h) m_cnt[i] <= m_cnt[i] + 64'd1;
      end
    end
  end

  function automatic string tag_of(logic [11:0] a);
    if (a == 12'h108) return "R3";
    if (a == 12'h12C) return "R8";
    if (a == 12'h130 || a == 12'h134) return "R9";
    if (a >= 12'h10C && a < 12'h12C) return "R2";
    return "R10";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; rd_en_i = 0; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk_i);
    rd_en_i = 1; wr_en_i = 0; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 0;
    v = rdata_o;
  endtask

  // read and compare against the reference model
  task automatic rd_m(logic [11:0] a);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag_of(a), v, m_rdata);
  endtask

  task automatic rd_x(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    rd_x("R1", 12'h108, 0); rd_x("R1", 12'h12C, 0);
    rd_x("R1", 12'h134, 0); rd_x("R1", 12'h130, 0);
    for (int i = 0; i < 8; i++) rd_x("R1", 12'h10C + 12'(4*i), 0);

    // R2 config readback masks upper bits
    bus_wr(12'h118, 32'hFFFF_FFFF);
    rd_x("R2", 12'h118, 32'h0000_0FFF);

    // R7 id with bit 9 set never counts, line all ones
    ev_dir = '1;
    bus_wr(12'h10C, 32'h0000_0605);
    bus_wr(12'h12C, 8);
    bus_wr(12'h108, 3);
    repeat (10) @(negedge clk_i);
    bus_wr(12'h108, 0);
    rd_x("R7", 12'h134, 0); rd_x("R7", 12'h130, 0);
    bus_wr(12'h12C, 11);
    rd_x("R7", 12'h130, 0);

    // R5 level mode, both polarities, line 7 held high
    ev_dir = '0; ev_dir[7] = 1'b1;
    bus_wr(12'h110, 32'h0000_0407);
    bus_wr(12'h114, 32'h0000_0007);
    bus_wr(12'h108, 3);
    repeat (20) @(negedge clk_i);
    bus_wr(12'h108, 0);
    bus_wr(12'h12C, 9);
    rd_x("R5", 12'h130, 22);
    bus_wr(12'h12C, 10);
    rd_x("R5", 12'h130, 0);
    // R3 frozen after control written 0
    repeat (5) @(negedge clk_i);
    bus_wr(12'h12C, 9);
    rd_x("R3", 12'h130, 22);
    rd_x("R3", 12'h108, 0);

    // R4 clear zeroes every counter
    bus_wr(12'h108, 32'h10);
    for (int i = 0; i < 8; i++) begin
      bus_wr(12'h12C, 8 + i);
      rd_x("R4", 12'h134, 0); rd_x("R4", 12'h130, 0);
    end

    // R6 edge mode: line 9 toggles 4 times
    ev_dir = '0;
    bus_wr(12'h11C, 32'h0000_0C09);
    bus_wr(12'h120, 32'h0000_0809);
    bus_wr(12'h108, 3);
    for (int k = 0; k < 4; k++) begin
      ev_dir[9] = 1'b1; repeat (3) @(negedge clk_i);
      ev_dir[9] = 1'b0; repeat (3) @(negedge clk_i);
    end
    bus_wr(12'h108, 0);
    bus_wr(12'h12C, 12); rd_x("R6", 12'h130, 4);
    bus_wr(12'h12C, 13); rd_x("R6", 12'h130, 4);

    // R4 clear wins over increment (counter 2: active low on low line)
    bus_wr(12'h108, 3);
    repeat (4) @(negedge clk_i);
    bus_wr(12'h108, 32'h13);
    bus_wr(12'h108, 0);
    bus_wr(12'h12C, 10);
    rd_x("R4", 12'h130, 2);
    rd_x("R4", 12'h108, 0);

    // R8 codes below 8 select nothing
    bus_wr(12'h12C, 3);
    rd_x("R8", 12'h12C, 3);
    rd_x("R8", 12'h134, 0); rd_x("R8", 12'h130, 0);

    // R9 coherence: high read captures low half while counting continues
    ev_dir[7] = 1'b1;
    bus_wr(12'h12C, 9);
    bus_wr(12'h108, 3);
    repeat (3) @(negedge clk_i);
    rd_m(12'h134);
    repeat (5) @(negedge clk_i);
    rd_m(12'h130);
    rd_m(12'h130);
    bus_wr(12'h108, 0);

    // R10 unmapped write ignored, unmapped read zero
    bus_wr(12'h200, 32'hFFFF_FFFF);
    rd_x("R10", 12'h200, 0);
    rd_x("R10", 12'h104, 0);
    for (int i = 0; i < 8; i++) rd_m(12'h10C + 12'(4*i));

    // random phase against the model
    ev_rand = 1'b1;
    bus_wr(12'h108, 3);
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 8) begin
        logic [31:0] d;
        d = $urandom_range(0, 31);
        if ($urandom_range(0, 7) == 0) d |= 32'h200;
        d |= ($urandom & 32'h0C00);
        bus_wr(12'h10C + 12'(4 * $urandom_range(0, 7)), d);
      end else if (op < 12) begin
        logic [31:0] d;
        d = ($urandom_range(0, 9) == 0) ? 32'h13 : (($urandom_range(0, 5) == 0) ? 32'h1 : 32'h3);
        bus_wr(12'h108, d);
      end else if (op < 20) begin
        bus_wr(12'h12C, ($urandom_range(0, 5) == 0) ? $urandom_range(0, 15) : 8 + $urandom_range(0, 7));
      end else if (op < 55) begin
        int s;
        s = $urandom_range(0, 9);
        case (s)
          0: rd_m(12'h108);
          1: rd_m(12'h12C);
          2, 3, 4: rd_m(12'h134);
          5, 6, 7: rd_m(12'h130);
          8: rd_m(12'h10C + 12'(4 * $urandom_range(0, 7)));
          default: rd_m(12'h0FC);
        endcase
      end else begin
        @(negedge clk_i);
      end
    end
    ev_rand = 1'b0;
    finish_run();
  end
endmodule